// File: doc/BRIEF.md
# Configurable Serial Transmitter with Line Control

This block turns bytes written by a host into asynchronous serial frames on a single output line. A line-control word sets the frame format at run time: the number of data bits, the parity scheme, and the number of stop bits. A small queue can hold several characters while earlier ones are still being shifted out. When the queue is switched off, the block falls back to a single holding slot.

Two enable bits gate the start of each frame, and both must be set. Bit timing comes from an external baud tick, which pulses once per oversampling period. Each serial bit lasts a fixed number of these ticks. The host polls a busy flag to learn when the line has gone quiet, and a full flag to learn when a further write would be lost.

The format is captured when a character is taken from the queue. A change to the line-control word therefore never corrupts a frame already on the line.

Top module: `uart_line_tx`

## Requirements
- R1: After reset, and whenever busy is low, `txd` is high, `busy` is low and `tx_full` is low.
- R2: Every frame begins with exactly one low start bit, followed by the data bits least significant first. Each bit holds for 16 `baud_tick` pulses.
- R3: `lcr_wlen` selects the word length as the length minus five (0 gives 5 bits, 3 gives 8 bits). Bits of `wr_data` above the selected length are not sent.
- R4: With `lcr_parity_en` high and `lcr_stick` low, one parity bit follows the data. With `lcr_even` high, the parity bit makes the count of ones in data plus parity even. With `lcr_even` low, it makes that count odd. With `lcr_parity_en` low, no parity bit is sent.
- R5: With `lcr_parity_en` and `lcr_stick` both high, the parity bit is the constant 1 when `lcr_even` is low and the constant 0 when `lcr_even` is high.
- R6: `lcr_two_stop` high ends each frame with two high stop bits; low ends it with one.
- R7: A frame starts only while both `ctl_tx_en` and `ctl_uart_en` are high. Clearing `ctl_uart_en` during a frame lets that frame complete, and no further frame starts until the enables return.
- R8: With `lcr_fifo_en` high, up to 16 characters are queued and sent in write order. `tx_full` is high while 16 are held, and a write while full is dropped.
- R9: With `lcr_fifo_en` low, the queue holds one character and `tx_full` rises after one write. A high-to-low change of `lcr_fifo_en` discards every queued character.
- R10: `busy` rises in the cycle after an accepted write. It stays high until the tick that ends the last stop bit of the final queued character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to queue |
| lcr_wlen | input | 2 | Word length minus five |
| lcr_parity_en | input | 1 | Parity bit present |
| lcr_even | input | 1 | Even parity select (stick value 0 when set) |
| lcr_stick | input | 1 | Constant parity select |
| lcr_two_stop | input | 1 | Two stop bits |
| lcr_fifo_en | input | 1 | Queue enable; falling edge flushes |
| ctl_tx_en | input | 1 | Transmit enable |
| ctl_uart_en | input | 1 | Block enable |
| baud_tick | input | 1 | One pulse per oversampling period |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Characters queued or frame on the line |
| tx_full | output | 1 | Queue cannot accept a write |

## Verification
A corrupted bit index or tick count shows within one frame as a frame of the wrong length. Because the decoder samples each bit in its middle, that error lands in the data, parity or stop field. A wrong parity or stop-count latch shows on the very next frame. Busy is required to fall exactly eight ticks after the middle of the last stop bit, so an extra or missing bit period is caught at the end of the frame. Queue pointer or count faults show as reordered or missing characters when 16 queued frames are decoded in order. They also show as a full flag that rises at the wrong write, or as busy staying high after a flush.

// File: rtl/uart_line_tx_pkg.sv
package uart_line_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // Mask keeping the low (len_code + 5) bits of a character.
    function automatic logic [7:0] len_mask(input logic [1:0] len_code);
        return 8'hFF >> (2'd3 - len_code);
    endfunction

endpackage

// File: rtl/uart_tx_fmt.sv
module uart_tx_fmt (
    input  logic [7:0] raw_data,
    input  logic [1:0] len_code,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    output logic [7:0] fmt_data,
    output logic [2:0] last_idx,
    output logic       par_bit,
    output logic       par_on
);
    import uart_line_tx_pkg::*;

    always_comb begin
        fmt_data = raw_data & len_mask(len_code);
        last_idx = {1'b0, len_code} + 3'd4;
        par_on   = par_en;
        if (par_stick) begin
            par_bit = ~par_even;
        end else if (par_even) begin
            par_bit = ^fmt_data;
        end else begin
            par_bit = ~(^fmt_data);
        end
    end

endmodule

// File: rtl/uart_tx_queue.sv
module uart_tx_queue #(
    parameter int DEPTH = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             q_enable,
    input  logic                             push,
    input  logic [7:0]                       push_data,
    input  logic                             pop,
    output logic [7:0]                       pop_data,
    output logic                             empty,
    output logic                             full,
    output logic [$clog2(DEPTH+1)-1:0]       count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
        logic             en_q;
    } queue_s;

    queue_s q_q, q_d;
    logic [7:0] mem [DEPTH];
    logic flush, push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = q_enable ? (q_q.cnt == CNT_W'(DEPTH)) : (q_q.cnt != '0);
    assign empty = (q_q.cnt == '0);
    assign count = q_q.cnt;
    assign pop_data = mem[q_q.rptr];

    always_comb begin
        q_d     = q_q;
        q_d.en_q = q_enable;
        flush   = q_q.en_q && !q_enable;
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
        if (flush) begin
            q_d.wptr = '0;
            q_d.rptr = '0;
            q_d.cnt  = '0;
        end else begin
            if (push_ok) q_d.wptr = step(q_q.wptr);
            if (pop_ok)  q_d.rptr = step(q_q.rptr);
            case ({push_ok, pop_ok})
                2'b10:   q_d.cnt = q_q.cnt + 1'b1;
                2'b01:   q_d.cnt = q_q.cnt - 1'b1;
                default: q_d.cnt = q_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[q_q.wptr] <= push_data;
        end
    end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       go_en,
    input  logic       src_valid,
    input  logic [7:0] src_data,
    input  logic [1:0] len_code,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    input  logic       two_stop,
    output logic       src_pop,
    output logic       active,
    output logic       txd
);
    import uart_line_tx_pkg::*;

    localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

    typedef struct packed {
        tx_state_e   state;
        logic [TW-1:0] tcnt;
        logic [2:0]  bidx;
        logic [2:0]  last;
        logic [7:0]  sh;
        logic        par_on;
        logic        par_bit;
        logic        two_stop;
        logic        stop2;
    } shift_s;

    shift_s s_q, s_d;
    logic [7:0] f_data;
    logic [2:0] f_last;
    logic       f_par, f_par_on;
    logic       bit_end;

    uart_tx_fmt u_fmt (
        .raw_data (src_data),
        .len_code (len_code),
        .par_en   (par_en),
        .par_even (par_even),
        .par_stick(par_stick),
        .fmt_data (f_data),
        .last_idx (f_last),
        .par_bit  (f_par),
        .par_on   (f_par_on)
    );

    assign bit_end = baud_tick && (s_q.tcnt == TW'(TICKS_PER_BIT - 1));
    assign active  = (s_q.state != ST_IDLE);

    always_comb begin
        case (s_q.state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = s_q.sh[0];
            ST_PARITY: txd = s_q.par_bit;
            default:   txd = 1'b1;
        endcase
    end

    always_comb begin
        s_d     = s_q;
        src_pop = 1'b0;
        if (s_q.state == ST_IDLE) begin
            if (src_valid && go_en) begin
                src_pop      = 1'b1;
                s_d.state    = ST_START;
                s_d.tcnt     = '0;
                s_d.bidx     = '0;
                s_d.last     = f_last;
                s_d.sh       = f_data;
                s_d.par_on   = f_par_on;
                s_d.par_bit  = f_par;
                s_d.two_stop = two_stop;
                s_d.stop2    = 1'b0;
            end
        end else if (baud_tick) begin
            s_d.tcnt = bit_end ? '0 : s_q.tcnt + 1'b1;
            if (bit_end) begin
                case (s_q.state)
                    ST_START: begin
                        s_d.state = ST_DATA;
                        s_d.bidx  = '0;
                    end
                    ST_DATA: begin
                        s_d.sh = s_q.sh >> 1;
                        if (s_q.bidx == s_q.last) begin
                            s_d.state = s_q.par_on ? ST_PARITY : ST_STOP;
                            s_d.stop2 = 1'b0;
                        end else begin
                            s_d.bidx = s_q.bidx + 1'b1;
                        end
                    end
                    ST_PARITY: begin
                        s_d.state = ST_STOP;
                        s_d.stop2 = 1'b0;
                    end
                    ST_STOP: begin
                        if (s_q.two_stop && !s_q.stop2) begin
                            s_d.stop2 = 1'b1;
                        end else begin
                            s_d.state = ST_IDLE;
                        end
                    end
                    default: s_d.state = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/uart_line_tx.sv
module uart_line_tx #(
    parameter int FIFO_DEPTH    = 16,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] lcr_wlen,
    input  logic       lcr_parity_en,
    input  logic       lcr_even,
    input  logic       lcr_stick,
    input  logic       lcr_two_stop,
    input  logic       lcr_fifo_en,
    input  logic       ctl_tx_en,
    input  logic       ctl_uart_en,
    input  logic       baud_tick,
    output logic       txd,
    output logic       busy,
    output logic       tx_full
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [7:0]       q_data;
    logic             q_empty;
    logic             q_pop;
    logic [CNT_W-1:0] fifo_count;
    logic             shift_active;

    uart_tx_queue #(.DEPTH(FIFO_DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .q_enable (lcr_fifo_en),
        .push     (wr_en),
        .push_data(wr_data),
        .pop      (q_pop),
        .pop_data (q_data),
        .empty    (q_empty),
        .full     (tx_full),
        .count    (fifo_count)
    );

    uart_tx_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .baud_tick(baud_tick),
        .go_en    (ctl_tx_en && ctl_uart_en),
        .src_valid(!q_empty),
        .src_data (q_data),
        .len_code (lcr_wlen),
        .par_en   (lcr_parity_en),
        .par_even (lcr_even),
        .par_stick(lcr_stick),
        .two_stop (lcr_two_stop),
        .src_pop  (q_pop),
        .active   (shift_active),
        .txd      (txd)
    );

    assign busy = !q_empty || shift_active;

endmodule

// File: rtl/uart_line_tx_chk.sv
module uart_line_tx_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             lcr_fifo_en,
    input logic             ctl_tx_en,
    input logic             ctl_uart_en,
    input logic             txd,
    input logic             busy,
    input logic             tx_full,
    input logic [CNT_W-1:0] fifo_count,
    input logic             shift_active
);

    assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctl_tx_en && ctl_uart_en) && !shift_active) |=> !shift_active);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && wr_en) |=> (fifo_count <= $past(fifo_count)));

    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcr_fifo_en) |=> (fifo_count == '0));

    assert_single_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcr_fifo_en && !$past(lcr_fifo_en)) |-> (fifo_count <= 1));

    assert_write_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tx_full && !$fell(lcr_fifo_en)) |=> busy);

endmodule

bind uart_line_tx uart_line_tx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .lcr_fifo_en (lcr_fifo_en),
    .ctl_tx_en   (ctl_tx_en),
    .ctl_uart_en (ctl_uart_en),
    .txd         (txd),
    .busy        (busy),
    .tx_full     (tx_full),
    .fifo_count  (fifo_count),
    .shift_active(shift_active)
);

// File: tb/tb_uart_line_tx.sv
`timescale 1ns/1ps
module tb_uart_line_tx;

    localparam int DEPTH = 16;
    localparam int NVEC  = 8;
    // {wlen[1:0], parity_en, even, stick, two_stop, data[7:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C},
        {2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 8'h81},
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hF3},
        {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hEA},
        {2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 8'h55},
        {2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 8'h7F},
        {2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'hE0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] lcr_wlen = 2'd3;
    logic       lcr_parity_en = 1'b0;
    logic       lcr_even = 1'b0;
    logic       lcr_stick = 1'b0;
    logic       lcr_two_stop = 1'b0;
    logic       lcr_fifo_en = 1'b0;
    logic       ctl_tx_en = 1'b0;
    logic       ctl_uart_en = 1'b0;
    logic       baud_tick;
    logic       txd, busy, tx_full;
    logic [1:0] div = 2'd0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) div <= div + 2'd1;
    assign baud_tick = (div == 2'd3);

    uart_line_tx dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .lcr_wlen(lcr_wlen), .lcr_parity_en(lcr_parity_en), .lcr_even(lcr_even),
        .lcr_stick(lcr_stick), .lcr_two_stop(lcr_two_stop), .lcr_fifo_en(lcr_fifo_en),
        .ctl_tx_en(ctl_tx_en), .ctl_uart_en(ctl_uart_en), .baud_tick(baud_tick),
        .txd(txd), .busy(busy), .tx_full(tx_full)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(posedge clk iff baud_tick);
        @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_fmt(input logic [13:0] v);
        @(negedge clk);
        lcr_wlen = v[13:12];
        lcr_parity_en = v[11];
        lcr_even = v[10];
        lcr_stick = v[9];
        lcr_two_stop = v[8];
    endtask

    // Line must stay high for n ticks.
    task automatic quiet(input int n, input string req);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            ticks(1);
            if (!txd) lows++;
        end
        check(lows == 0, req, lows, 0);
    endtask

    task automatic decode(input logic [13:0] v, input bit chk_end);
        logic [7:0] exp_d, got;
        logic       exp_p;
        int nbits, waited, n;
        nbits = int'(v[13:12]) + 5;
        exp_d = v[7:0] & (8'hFF >> (2'd3 - v[13:12]));
        if (v[9]) exp_p = ~v[10];
        else if (v[10]) exp_p = ^exp_d;
        else exp_p = ~(^exp_d);
        waited = 0;
        @(negedge clk);
        while (txd && waited < 6000) begin
            @(negedge clk);
            waited++;
        end
        check(!txd, "R2", txd, 0);
        if (txd) return;
        ticks(8);
        check(txd == 1'b0, "R2", txd, 0);
        got = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            ticks(16);
            got[i] = txd;
        end
        check(got == exp_d, (v[13:12] != 2'd3) ? "R3" : "R2", got, exp_d);
        if (v[11]) begin
            ticks(16);
            check(txd == exp_p, v[9] ? "R5" : "R4", txd, exp_p);
        end
        ticks(16);
        check(txd == 1'b1, "R6", txd, 1);
        if (v[8]) begin
            ticks(16);
            check(txd == 1'b1, "R6", txd, 1);
        end
        if (chk_end) begin
            n = 0;
            while (busy && n < 40) begin
                ticks(1);
                n++;
            end
            check(n == 8, "R10", n, 8);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1", txd, 1);
        check(busy == 1'b0, "R1", busy, 0);
        check(tx_full == 1'b0, "R1", tx_full, 0);

        // Vector table: single-slot mode, enables on
        ctl_tx_en = 1'b1;
        ctl_uart_en = 1'b1;
        for (int k = 0; k < NVEC; k++) begin
            set_fmt(VEC[k]);
            write_byte(VEC[k][7:0]);
            decode(VEC[k], 1'b1);
        end

        // R7 gating: transmit disabled, then enabled
        set_fmt(VEC[0]);
        @(negedge clk);
        ctl_tx_en = 1'b0;
        write_byte(8'h5A);
        check(busy == 1'b1, "R10", busy, 1);
        quiet(40, "R7");
        @(negedge clk);
        ctl_tx_en = 1'b1;
        decode({6'b110000, 8'h5A}, 1'b1);

        // R7 block enable cleared mid-frame
        @(negedge clk);
        lcr_fifo_en = 1'b1;
        ctl_tx_en = 1'b0;
        write_byte(8'hC3);
        write_byte(8'h3E);
        @(negedge clk);
        ctl_tx_en = 1'b1;
        fork
            decode({6'b110000, 8'hC3}, 1'b0);
            begin
                ticks(50);
                ctl_uart_en = 1'b0;
            end
        join
        quiet(40, "R7");
        check(busy == 1'b1, "R7", busy, 1);
        @(negedge clk);
        ctl_uart_en = 1'b1;
        decode({6'b110000, 8'h3E}, 1'b1);

        // R8 queue fill, overflow drop, ordered drain
        @(negedge clk);
        ctl_tx_en = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            write_byte(8'(i * 7 + 3));
            if (i == DEPTH - 2) check(tx_full == 1'b0, "R8", tx_full, 0);
        end
        check(tx_full == 1'b1, "R8", tx_full, 1);
        write_byte(8'hFF);
        @(negedge clk);
        ctl_tx_en = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            decode({6'b110000, 8'(i * 7 + 3)}, i == DEPTH - 1);
        end

        // R9 single slot
        @(negedge clk);
        lcr_fifo_en = 1'b0;
        ctl_tx_en = 1'b0;
        write_byte(8'h11);
        check(tx_full == 1'b1, "R9", tx_full, 1);
        write_byte(8'h22);
        @(negedge clk);
        ctl_tx_en = 1'b1;
        decode({6'b110000, 8'h11}, 1'b1);

        // R9 flush on clearing queue enable
        @(negedge clk);
        lcr_fifo_en = 1'b1;
        ctl_tx_en = 1'b0;
        write_byte(8'h01);
        write_byte(8'h02);
        write_byte(8'h03);
        check(busy == 1'b1 && tx_full == 1'b0, "R9", {busy, tx_full}, 2);
        @(negedge clk);
        lcr_fifo_en = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R9", busy, 0);
        ctl_tx_en = 1'b1;
        quiet(40, "R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule